// File: doc/BRIEF.md
# Smart card character receiver with error signalling

This block receives asynchronous characters from a smart card over one shared, open-drain data line. The line is oversampled by the core clock. Each bit lasts one elementary time unit (ETU) of `ETU` clock cycles. A character has four parts, in this order:

- a low start bit,
- eight data bits, least significant bit first,
- one even parity bit,
- a guard period.

Every bit is sampled at its midpoint. When the parity check passes, the character goes into a holding register and a full flag is raised. When the parity check fails, the block raises a parity error flag. It also pulls the line low for one ETU during the guard period. The card reads this pulse as a request to send the same character again. The retransmitted copy is then received as an ordinary new frame.

The holding register is emptied by a read strobe. That strobe may come from a processor or from a DMA engine. The parity error flag and the overrun flag are sticky. Each is cleared by its own clear input. Both interrupt outputs are gated by one enable input. The line input passes through a two-stage synchronizer and a falling-edge detector. These add three clock cycles of latency between a change on the pin and the point where the receiver acts on it. All timing below includes that latency.

Top module: `sc_rx_top`

## Requirements
- R1: While reset is asserted and just after it is released, these outputs are all 0: `full_o`, `perr_o`, `ovr_o`, `line_drv_o`, `rx_irq_o` and `err_irq_o`.
- R2: Let a falling edge reach `line_i` just after clock edge k. If the character has even parity, meaning the eight data bits and the parity bit together hold an even number of ones, two things happen at clock edge k+3+9*ETU+ETU/2 (the parity midpoint). `rx_data_o` takes the data byte, with the first data bit received in bit 0. `full_o` rises.
- R3: A character with odd parity sets `perr_o` at its parity midpoint. It leaves `rx_data_o` unchanged, and it leaves `full_o` unchanged.
- R4: After a parity error, `line_drv_o` goes to 1 at clock edge k+3+10*ETU+ETU/2. It stays at 1 for exactly ETU cycles. After a good character it stays at 0 for the whole frame.
- R5: A character that follows an errored one is received as a normal new frame. A correct copy therefore loads `rx_data_o` and sets `full_o`.
- R6: A one-cycle pulse on `rd_strobe_i` clears `full_o` at the next clock edge.
- R7: `perr_o` stays at 1 until `perr_clr_i` is pulsed. If a parity error and `perr_clr_i` fall in the same cycle, `perr_o` stays at 1.
- R8: Suppose the line goes low but is high again at the midpoint of the start bit. Then no character is received, and the line is not driven. The next genuine character is received normally.
- R9: Suppose a good character completes while `full_o` is 1 and no read strobe comes in that cycle. Then `rx_data_o` keeps its old value and `ovr_o` goes to 1. `ovr_o` is cleared by `ovr_clr_i`.
- R10: Suppose `rd_strobe_i` is high in the same cycle that a good character completes. Then the new byte is written, `full_o` stays at 1, and `ovr_o` is not set.
- R11: `rx_irq_o` is the logical AND of `full_o` and `irq_en_i`. `err_irq_o` is the logical AND of (`perr_o` OR `ovr_o`) and `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the line |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level currently seen on the shared data line |
| line_drv_o | output | 1 | 1 pulls the line low for the error signal; 0 releases it |
| rd_strobe_i | input | 1 | Holding register read pulse; clears the full flag |
| rx_data_o | output | DW | Holding register with the last accepted byte |
| full_o | output | 1 | Holding register contains an unread byte |
| perr_o | output | 1 | Sticky parity error flag |
| perr_clr_i | input | 1 | Clears the parity error flag |
| ovr_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| irq_en_i | input | 1 | Enables both interrupt outputs |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Two pairs of events can fall in the same clock cycle.

- The completion of a good character can coincide with a read of the holding register.
- A parity failure can coincide with a parity error clear.

The bench provokes both cases. From the cycle of the start edge it computes the cycle in which the parity midpoint takes effect, then raises the strobe or the clear exactly one cycle before that edge. In the first case it expects the new byte to be in the register, with the full flag still set and no overrun. A second run moves the read one cycle later; there it expects an overrun, the old byte kept, and the full flag then cleared. In the parity case it expects the error flag to stay set.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_BITS
  } rx_state_e;
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_s = s2_q;
  assign fall   = s3_q & ~s2_q;
endmodule

// File: rtl/sc_rx_etu.sv
module sc_rx_etu #(
  parameter int ETU = 372
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mid,
  output logic last
);
  localparam int CW = (ETU > 2) ? $clog2(ETU) : 1;
  localparam logic [CW-1:0] MID_C  = CW'(ETU / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(ETU - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign mid  = run && (cnt_q == MID_C);
  assign last = run && (cnt_q == LAST_C);

  always_comb begin
    if (!run)      cnt_n = '0;
    else if (last) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  input  logic          fall,
  input  logic          mid,
  input  logic          last,
  output logic          busy,
  output logic          good_p,
  output logic          bad_p,
  output logic [DW-1:0] shift_o,
  output logic          drv_o
);
  localparam int BW = $clog2(DW + 4);
  localparam logic [BW-1:0] IX_START = '0;
  localparam logic [BW-1:0] IX_DLAST = BW'(DW);
  localparam logic [BW-1:0] IX_PAR   = BW'(DW + 1);
  localparam logic [BW-1:0] IX_SIGON = BW'(DW + 2);

  rx_state_e     state_q, state_n;
  logic [BW-1:0] ix_q, ix_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          par_q, par_n;
  logic          err_q, err_n;
  logic          drv_q, drv_n;

  always_comb begin
    state_n = state_q;
    ix_n    = ix_q;
    sh_n    = sh_q;
    par_n   = par_q;
    err_n   = err_q;
    drv_n   = drv_q;
    good_p  = 1'b0;
    bad_p   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_n = ST_BITS;
          ix_n    = '0;
          par_n   = 1'b0;
          err_n   = 1'b0;
        end
      end
      default: begin
        if (mid) begin
          if (ix_q == IX_START) begin
            if (line_s) state_n = ST_IDLE;
          end else if (ix_q <= IX_DLAST) begin
            sh_n  = {line_s, sh_q[DW-1:1]};
            par_n = par_q ^ line_s;
          end else if (ix_q == IX_PAR) begin
            if (par_q ^ line_s) begin
              bad_p = 1'b1;
              err_n = 1'b1;
            end else begin
              good_p = 1'b1;
            end
          end else if (ix_q == IX_SIGON) begin
            drv_n = err_q;
          end else begin
            drv_n   = 1'b0;
            state_n = ST_IDLE;
          end
        end
        if (last) ix_n = ix_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ix_q    <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      err_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ix_q    <= ix_n;
      sh_q    <= sh_n;
      par_q   <= par_n;
      err_q   <= err_n;
      drv_q   <= drv_n;
    end
  end

  assign busy    = (state_q == ST_BITS);
  assign shift_o = sh_q;
  assign drv_o   = drv_q;
endmodule

// File: rtl/sc_rx_top.sv
module sc_rx_top #(
  parameter int ETU = 372,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  output logic          line_drv_o,
  input  logic          rd_strobe_i,
  output logic [DW-1:0] rx_data_o,
  output logic          full_o,
  output logic          perr_o,
  input  logic          perr_clr_i,
  output logic          ovr_o,
  input  logic          ovr_clr_i,
  input  logic          irq_en_i,
  output logic          rx_irq_o,
  output logic          err_irq_o
);
  logic          line_s, fall, busy, mid, last;
  logic          good_p, bad_p;
  logic [DW-1:0] shift_w;

  sc_rx_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(line_i),
    .line_s(line_s),
    .fall  (fall)
  );

  sc_rx_etu #(.ETU(ETU)) u_etu (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .mid  (mid),
    .last (last)
  );

  sc_rx_frame #(.DW(DW)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_s (line_s),
    .fall   (fall),
    .mid    (mid),
    .last   (last),
    .busy   (busy),
    .good_p (good_p),
    .bad_p  (bad_p),
    .shift_o(shift_w),
    .drv_o  (line_drv_o)
  );

  logic [DW-1:0] data_q;
  logic          full_q, full_n;
  logic          perr_q, perr_n;
  logic          ovr_q, ovr_n;
  logic          wr_en;

  always_comb begin
    wr_en  = good_p & (~full_q | rd_strobe_i);
    full_n = wr_en | (full_q & ~rd_strobe_i);
    ovr_n  = (good_p & full_q & ~rd_strobe_i) | (ovr_q & ~ovr_clr_i);
    perr_n = bad_p | (perr_q & ~perr_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      perr_q <= perr_n;
      ovr_q  <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_en) data_q <= shift_w;
  end

  assign rx_data_o = data_q;
  assign full_o    = full_q;
  assign perr_o    = perr_q;
  assign ovr_o     = ovr_q;
  assign rx_irq_o  = full_q & irq_en_i;
  assign err_irq_o = (perr_q | ovr_q) & irq_en_i;
endmodule

// File: rtl/sc_rx_chk.sv
module sc_rx_chk #(
  parameter int ETU = 372,
  parameter int DW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_strobe_i,
  input logic          perr_clr_i,
  input logic          line_drv_o,
  input logic          full_o,
  input logic          perr_o,
  input logic          ovr_o,
  input logic [DW-1:0] rx_data_o,
  input logic          good_p,
  input logic          bad_p
);
  int unsigned drv_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          drv_run <= 0;
    else if (line_drv_o) drv_run <= drv_run + 1;
    else                 drv_run <= 0;
  end

  AST_DRV_MAX: assert property (@(posedge clk) disable iff (!rst_n) drv_run <= ETU); // R4
  AST_DRV_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(line_drv_o) |-> drv_run == ETU); // R4
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bad_p |=> $stable(rx_data_o) && perr_o); // R3
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rd_strobe_i && !good_p |=> !full_o); // R6
  AST_PERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) perr_o && !perr_clr_i |=> perr_o); // R7
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) good_p && full_o && !rd_strobe_i |=> ovr_o && $stable(rx_data_o)); // R9
  AST_SAME_CYCLE_RD: assert property (@(posedge clk) disable iff (!rst_n) good_p && rd_strobe_i |=> full_o); // R10
endmodule

bind sc_rx_top sc_rx_chk #(.ETU(ETU), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_strobe_i(rd_strobe_i),
  .perr_clr_i (perr_clr_i),
  .line_drv_o (line_drv_o),
  .full_o     (full_o),
  .perr_o     (perr_o),
  .ovr_o      (ovr_o),
  .rx_data_o  (rx_data_o),
  .good_p     (good_p),
  .bad_p      (bad_p)
);

// File: tb/tb_sc_rx_top.sv
`timescale 1ns/1ps
module tb_sc_rx_top;
  localparam int ETU  = 16;
  localparam int HALF = ETU / 2;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n, card, rd, pclr, oclr, ien;
  logic line_i, drv, full, perr, ovr, rxirq, errirq;
  logic [DW-1:0] data;

  always #2 clk = ~clk;

  assign line_i = card & ~drv;

  sc_rx_top #(.ETU(ETU), .DW(DW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .line_drv_o (drv),
    .rd_strobe_i(rd),
    .rx_data_o  (data),
    .full_o     (full),
    .perr_o     (perr),
    .perr_clr_i (pclr),
    .ovr_o      (ovr),
    .ovr_clr_i  (oclr),
    .irq_en_i   (ien),
    .rx_irq_o   (rxirq),
    .err_irq_o  (errirq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int drv_cnt, rise_cyc, full_rise_cyc;
  logic drv_prev = 1'b0, full_prev = 1'b0;
  always @(negedge clk) begin
    if (drv) drv_cnt = drv_cnt + 1;
    if (drv && !drv_prev) rise_cyc = cyc;
    if (full && !full_prev) full_rise_cyc = cyc;
    drv_prev  = drv;
    full_prev = full;
  end

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic m_full, m_perr, m_ovr;
  logic [DW-1:0] m_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [DW-1:0] d);
    return ^d;
  endfunction

  task automatic send_frame(input logic [DW-1:0] d, input bit badp);
    logic [9:0] bits;
    bits = {even_par(d) ^ badp, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      card = bits[i];
      repeat (ETU) @(posedge clk);
      #1;
    end
    card = 1'b1;
    repeat (3 * ETU) @(posedge clk);
    #1;
  endtask

  task automatic check_state(input string tg);
    chk({tg, " data"}, data, m_data);
    chk({tg, " full"}, full, m_full);
    chk({tg, " perr"}, perr, m_perr);
    chk({tg, " ovr"}, ovr, m_ovr);
    chk("R11 rx irq", rxirq, m_full & ien);
    chk("R11 err irq", errirq, (m_perr | m_ovr) & ien);
  endtask

  // mode 0: none, 1: read one cycle before completion edge, 2: read one cycle later,
  // 3: parity error clear one cycle before completion edge
  task automatic run_frame(input logic [DW-1:0] d, input bit badp, input int mode, input string tg);
    int k, tgt, when;
    logic pre_full;
    pre_full      = m_full;
    drv_cnt       = 0;
    rise_cyc      = -1;
    full_rise_cyc = -1;
    k    = cyc;
    tgt  = k + 3 + 9 * ETU + HALF;
    when = (mode == 2) ? tgt : tgt - 1;
    fork
      send_frame(d, badp);
      begin
        if (mode != 0) begin
          do begin
            @(posedge clk);
            #1;
          end while (cyc != when);
          if (mode == 3) pclr = 1'b1;
          else           rd = 1'b1;
          @(posedge clk);
          #1;
          rd   = 1'b0;
          pclr = 1'b0;
        end
      end
    join
    if (!badp) begin
      if (!m_full || mode == 1) begin
        m_data = d;
        m_full = 1'b1;
      end else begin
        m_ovr = 1'b1;
      end
      if (mode == 2) m_full = 1'b0;
    end else begin
      m_perr = 1'b1;
    end
    check_state(tg);
    chk("R4 drive length", drv_cnt, badp ? ETU : 0);
    if (badp) chk("R4 drive start", rise_cyc, k + 3 + 10 * ETU + HALF);
    if (!badp && !pre_full && mode == 0) chk({tg, " completion cycle"}, full_rise_cyc, tgt);
  endtask

  task automatic pulse_rd();
    rd = 1'b1; @(posedge clk); #1; rd = 1'b0; m_full = 1'b0;
  endtask
  task automatic pulse_pclr();
    pclr = 1'b1; @(posedge clk); #1; pclr = 1'b0; m_perr = 1'b0;
  endtask
  task automatic pulse_oclr();
    oclr = 1'b1; @(posedge clk); #1; oclr = 1'b0; m_ovr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    bit badp;
    void'($urandom(32'h5eed_0c4d));
    rst_n = 1'b0; card = 1'b1; rd = 1'b0; pclr = 1'b0; oclr = 1'b0; ien = 1'b1;
    m_full = 1'b0; m_perr = 1'b0; m_ovr = 1'b0; m_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 full in reset", full, 0);
    chk("R1 perr in reset", perr, 0);
    chk("R1 ovr in reset", ovr, 0);
    chk("R1 drive in reset", drv, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 full after reset", full, 0);
    chk("R1 irqs after reset", {rxirq, errirq}, 0);

    run_frame(8'hA5, 0, 0, "R2");
    pulse_rd();
    chk("R6 read clears full", full, 0);
    run_frame(8'h3C, 1, 0, "R3");
    run_frame(8'h3C, 0, 0, "R5");
    chk("R7 perr still set", perr, 1);
    run_frame(8'h81, 0, 0, "R9");
    pulse_oclr();
    chk("R9 ovr cleared", ovr, 0);
    pulse_pclr();
    chk("R7 perr cleared", perr, 0);
    run_frame(8'h5A, 0, 1, "R10");
    run_frame(8'h0F, 0, 2, "R9 late read");
    pulse_oclr();
    run_frame(8'h77, 1, 3, "R7 clear collision");
    pulse_pclr();

    drv_cnt = 0;
    card = 1'b0;
    repeat (HALF - 2) @(posedge clk);
    #1;
    card = 1'b1;
    repeat (13 * ETU) @(posedge clk);
    #1;
    check_state("R8 false start");
    chk("R8 no drive", drv_cnt, 0);
    run_frame(8'hC3, 0, 0, "R8 after glitch");

    ien = 1'b0;
    run_frame(8'h12, 1, 0, "R11 disabled");
    chk("R11 irqs masked", {rxirq, errirq}, 0);
    ien = 1'b1;
    #1;
    chk("R11 irqs enabled", {rxirq, errirq}, 2'b11);
    pulse_pclr();
    pulse_rd();

    for (int it = 0; it < 40; it++) begin
      d    = DW'($urandom);
      badp = ($urandom % 4) == 0;
      run_frame(d, badp, 0, badp ? "R3 rand" : "R2 rand");
      if (badp) run_frame(d, 0, 0, "R5 rand");
      if ($urandom % 2) pulse_rd();
      if ($urandom % 2) pulse_pclr();
      if ($urandom % 2) pulse_oclr();
      if ($urandom % 5 == 0) ien = ~ien;
      #1;
      check_state("R6 R7 R9 housekeeping");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule